// File: doc/BRIEF.md
# Instruction-Phase Serial Register Port

This block is a synchronous serial slave. It lets a host read and write a small bank of 8-bit configuration registers. The host pulls chip select low to open a communication cycle. It then clocks in an instruction byte, followed by one to four data bytes. The instruction byte selects the direction, the burst length and the first register address. After each data byte the address moves by one register. The block takes its registers from the bank and hands them to the surrounding logic on a flat output bus.

The host clock and data lines are sampled with the block clock `clk_i`. The serial clock must therefore run at less than half the block clock rate, and the serial inputs are taken to be synchronous to it already. Register 0 holds the port's own settings. Bit 0 selects LSB-first order. Bit 1 selects the 4-wire mode, in which read data leaves on `sdo_o`; in the 3-wire mode read data leaves on the shared data pin, through `sdio_o` and `sdio_oe_o`. A new setting takes effect only once chip select has returned high. The pad driver for the shared pin sits outside this block.

Top module: `sreg_port`

## Requirements
- R1: After reset, every register reads 0x00, `sdio_oe_o` and `sdo_o` are low, and the port is in MSB-first, 3-wire mode.
- R2: While `csn_i` is high, any partial cycle is discarded. A byte that is cut short is never written, and the next low period of `csn_i` starts again with the instruction phase at bit zero.
- R3: The first eight rising serial clock edges of a cycle build the instruction byte, with bit 7 = 1 for read and 0 for write, bits 6:5 = byte count minus one, and bits 4:0 = start address. In MSB-first mode the first serial bit is bit 7 of a byte; in LSB-first mode it is bit 0. This applies to instruction and data bytes alike.
- R4: The data phase moves exactly the number of bytes the instruction requested. Further serial clock edges before `csn_i` rises write nothing and drive nothing.
- R5: In a write, each data byte is stored at the current address on its eighth rising edge. The address then steps down by one in MSB-first mode or up by one in LSB-first mode, modulo 32.
- R6: In a read, each data bit is driven on a falling serial clock edge from the register at the current address, in the configured bit order. The first bit appears on the falling edge that follows the eighth instruction edge.
- R7: In 3-wire mode (register 0 bit 1 = 0), `sdio_oe_o` is high only from the first falling edge of a read data phase until the falling edge after the last data bit, or until `csn_i` rises; `sdo_o` stays low. In 4-wire mode, `sdio_oe_o` stays low and read data appears on `sdo_o`.
- R8: Register 0 bit 0 (LSB-first) and bit 1 (4-wire) take effect only after `csn_i` has been high. A write to register 0 does not change the handling of the rest of the same cycle.
- R9: An address at or above `NUM_REGS` is ignored on write and reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; samples all serial inputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csn_i | input | 1 | Chip select, active low; frames a cycle |
| sclk_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Serial data in (shared pin input path) |
| sdio_o | output | 1 | Read data toward the shared pin |
| sdio_oe_o | output | 1 | Output enable of the shared pin |
| sdo_o | output | 1 | Dedicated read data output (4-wire mode) |
| regs_o | output | NUM_REGS*8 | Register bank contents, register i at bits 8i+7:8i |

## Verification
The bench checks both burst directions at the full length of four bytes, and reads back in both bit orders. An address sequencer that steps the wrong way would scatter a burst over the wrong registers. A reversed shifter would return bit-mirrored bytes. The bench keeps clocking after the last requested byte and aborts cycles both inside the instruction and inside a data byte. A port that does not stop, or that does not clear its counters, would overwrite a neighbouring register. A port that drives in the wrong place would raise the output enable outside a read. Register 0 is rewritten in the middle of a burst. A design that applied the new bit order at once would store the next byte mirrored. Reads on the dedicated output confirm that the shared pin stays released in 4-wire mode.

// File: rtl/sreg_port_pkg.sv
package sreg_port_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;
  localparam int LEN_W  = 2;
  localparam int BIT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } phase_e;

  typedef struct packed {
    logic              rd;
    logic [LEN_W-1:0]  len_m1;
    logic [ADDR_W-1:0] addr;
  } instr_t;

  typedef struct packed {
    logic four_wire;
    logic lsb_first;
  } cfg_t;
endpackage

// File: rtl/sreg_shift.sv
module sreg_shift
  import sreg_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              lsb_first_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_done_o,
  output logic [BIT_W-1:0]  bit_cnt_o
);
  logic [BYTE_W-1:0] shift_q;
  logic [BIT_W-1:0]  cnt_q;

  always_comb begin
    if (lsb_first_i) byte_o = {bit_i, shift_q[BYTE_W-1:1]};
    else             byte_o = {shift_q[BYTE_W-2:0], bit_i};
  end

  assign byte_done_o = rise_i && (cnt_q == BIT_W'(BYTE_W-1));
  assign bit_cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (clr_i) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (rise_i) begin
      shift_q <= byte_o;
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  AST_CLR_RESTARTS_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/sreg_seq.sv
module sreg_seq
  import sreg_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              lsb_first_i,
  output phase_e            phase_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o
);
  phase_e            phase_q;
  logic              rd_q;
  logic [LEN_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_q;
  instr_t            instr;

  assign instr   = instr_t'(byte_i);
  assign phase_o = phase_q;
  assign rd_o    = rd_q;
  assign addr_o  = addr_q;
  assign wr_en_o = byte_done_i && (phase_q == PH_DATA) && !rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_INSTR;
      rd_q    <= 1'b0;
      left_q  <= '0;
      addr_q  <= '0;
    end else if (clr_i) begin
      phase_q <= PH_INSTR;
    end else if (byte_done_i) begin
      unique case (phase_q)
        PH_INSTR: begin
          rd_q    <= instr.rd;
          left_q  <= instr.len_m1;
          addr_q  <= instr.addr;
          phase_q <= PH_DATA;
        end
        PH_DATA: begin
          addr_q <= lsb_first_i ? addr_q + 1'b1 : addr_q - 1'b1;
          if (left_q == '0) phase_q <= PH_DONE;
          else              left_q  <= left_q - 1'b1;
        end
        default: phase_q <= PH_DONE;
      endcase
    end
  end

  AST_CLR_TO_INSTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (phase_q == PH_INSTR)); // R2
  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DONE && !clr_i) |=> (phase_q == PH_DONE)); // R4
  AST_NO_BYTE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DONE) |-> !byte_done_i); // R4
endmodule

// File: rtl/sreg_file.sv
module sreg_file
  import sreg_port_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [BYTE_W-1:0]          wdata_i,
  output logic [BYTE_W-1:0]          rdata_o,
  output cfg_t                       cfg_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  localparam int CFG_ADDR = 0;

  logic [BYTE_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(g))      regs_q[g] <= wdata_i;
    end
    assign regs_o[g*BYTE_W +: BYTE_W] = regs_q[g];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = regs_q[i];
  end

  assign cfg_o = cfg_t'(regs_q[CFG_ADDR][1:0]);

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(addr_i) >= NUM_REGS) |=> $stable(regs_o)); // R9
endmodule

// File: rtl/sreg_port.sv
module sreg_port
  import sreg_port_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       csn_i,
  input  logic                       sclk_i,
  input  logic                       sdio_i,
  output logic                       sdio_o,
  output logic                       sdio_oe_o,
  output logic                       sdo_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic              sclk_q, rise, fall, shift_rise;
  cfg_t              cfg_q, cfg_reg;
  logic              dout_q, drive_q;
  logic [BYTE_W-1:0] rx_byte, rdata;
  logic              byte_done, rd, wr_en;
  logic [BIT_W-1:0]  bit_cnt, rd_idx;
  logic [ADDR_W-1:0] addr;
  phase_e            phase;

  assign rise       = !csn_i && sclk_i && !sclk_q;
  assign fall       = !csn_i && !sclk_i && sclk_q;
  assign shift_rise = rise && (phase != PH_DONE);
  assign rd_idx     = cfg_q.lsb_first ? bit_cnt : BIT_W'(BYTE_W-1) - bit_cnt;

  sreg_shift i_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (csn_i),
    .rise_i      (shift_rise),
    .lsb_first_i (cfg_q.lsb_first),
    .bit_i       (sdio_i),
    .byte_o      (rx_byte),
    .byte_done_o (byte_done),
    .bit_cnt_o   (bit_cnt)
  );

  sreg_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (csn_i),
    .byte_done_i (byte_done),
    .byte_i      (rx_byte),
    .lsb_first_i (cfg_q.lsb_first),
    .phase_o     (phase),
    .rd_o        (rd),
    .addr_o      (addr),
    .wr_en_o     (wr_en)
  );

  sreg_file #(.NUM_REGS(NUM_REGS)) i_file (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (rx_byte),
    .rdata_o (rdata),
    .cfg_o   (cfg_reg),
    .regs_o  (regs_o)
  );

  // settings only move while the port is deselected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      cfg_q   <= '0;
      dout_q  <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      if (csn_i) begin
        cfg_q   <= cfg_reg;
        drive_q <= 1'b0;
      end else if (fall) begin
        drive_q <= (phase == PH_DATA) && rd;
        if ((phase == PH_DATA) && rd) dout_q <= rdata[rd_idx];
      end
    end
  end

  assign sdio_o    = dout_q;
  assign sdio_oe_o = drive_q && !cfg_q.four_wire;
  assign sdo_o     = drive_q && cfg_q.four_wire && dout_q;

  AST_OE_ONLY_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdio_oe_o |-> (rd && phase != PH_INSTR)); // R7
  AST_SDO_QUIET_3W: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.four_wire |-> !sdo_o); // R7
  AST_NO_OE_4W: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.four_wire |-> !sdio_oe_o); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csn_i && !$past(csn_i)) |-> $stable(cfg_q)); // R8
endmodule

// File: tb/test_sreg_port.sv
module test_sreg_port;
  localparam int CLK_P   = 10;
  localparam int N       = 8;
  localparam int MAX_CYC = 150000;

  logic clk = 1'b0, rst_ni = 1'b0, csn_i = 1'b1, sclk_i = 1'b0, sdio_i = 1'b0;
  logic sdio_o, sdio_oe_o, sdo_o;
  logic [N*8-1:0] regs_o;

  always #(CLK_P/2) clk = ~clk;

  sreg_port #(.NUM_REGS(N)) i_sreg_port (
    .clk_i(clk), .rst_ni(rst_ni), .csn_i(csn_i), .sclk_i(sclk_i), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe_o), .sdo_o(sdo_o), .regs_o(regs_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0, cmp_on = 0;
  logic [7:0] exp_regs [32];
  logic exp_lsb = 0, exp_4w = 0, exp_drive = 0, exp_bit = 0;

  function automatic void chk(input bit ok, input string tag,
                              input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  // reference compared on every clock
  always @(posedge clk) begin : cmp
    logic [N*8-1:0] e;
    #(CLK_P/4);
    if (cmp_on && !finished) begin
      for (int r = 0; r < N; r++) e[r*8 +: 8] = exp_regs[r];
      chk(regs_o === e, "R5 R9 register bank", 64'(regs_o), 64'(e));
      chk(sdio_oe_o === (exp_drive & !exp_4w), "R7 sdio_oe_o", 64'(sdio_oe_o), 64'(exp_drive & !exp_4w));
      chk(sdo_o === (exp_drive & exp_4w & exp_bit), "R6 R7 sdo_o", 64'(sdo_o), 64'(exp_drive & exp_4w & exp_bit));
      if (exp_drive && !exp_4w) chk(sdio_o === exp_bit, "R6 sdio_o", 64'(sdio_o), 64'(exp_bit));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC && !finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, MAX_CYC);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic fall_edge(input logic drv, input logic b, output logic got);
    sclk_i = 1'b0;
    @(posedge clk);
    exp_drive = drv;
    if (drv) exp_bit = b;
    @(negedge clk);
    got = exp_4w ? sdo_o : sdio_o;
  endtask

  task automatic rise_edge(input logic din, input logic we, input int wa, input logic [7:0] wv);
    sdio_i = din;
    @(negedge clk);
    sclk_i = 1'b1;
    @(posedge clk);
    if (we && wa < N) exp_regs[wa] = wv;
    @(negedge clk);
  endtask

  task automatic cs_high();
    csn_i = 1'b1;
    sclk_i = 1'b0;
    @(posedge clk);
    exp_drive = 1'b0;
    exp_lsb = exp_regs[0][0];
    exp_4w  = exp_regs[0][1];
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_cycle(input logic rd, input int cnt, input int a,
                           input logic [31:0] wd, input int extra, output logic [31:0] rdat);
    logic [7:0] ins, rb, wb;
    logic g;
    int cur, idx;
    ins = {rd, 2'(cnt-1), 5'(a)};
    csn_i = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      fall_edge(1'b0, 1'b0, g);
      rise_edge(exp_lsb ? ins[i] : ins[7-i], 1'b0, 0, 8'h0);
    end
    cur = a;
    rdat = '0;
    for (int k = 0; k < cnt; k++) begin
      wb = wd[k*8 +: 8];
      rb = (cur < N) ? exp_regs[cur] : 8'h00;
      for (int i = 0; i < 8; i++) begin
        idx = exp_lsb ? i : 7 - i;
        fall_edge(rd, rb[idx], g);
        if (rd) rdat[k*8 + idx] = g;
        rise_edge(wb[idx], !rd && i == 7, cur, wb);
      end
      cur = exp_lsb ? (cur + 1) % 32 : (cur + 31) % 32;
    end
    for (int e = 0; e < extra; e++) begin
      fall_edge(1'b0, 1'b0, g);
      rise_edge(1'b1, 1'b0, 0, 8'h0);
    end
    fall_edge(1'b0, 1'b0, g);
    cs_high();
  endtask

  task automatic abort_cycle(input logic [15:0] pat, input int nbits);
    logic g;
    csn_i = 1'b0;
    @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      fall_edge(1'b0, 1'b0, g);
      rise_edge(pat[i], 1'b0, 0, 8'h0);
    end
    cs_high();
  endtask

  initial begin
    logic [31:0] d;
    logic [15:0] p;
    for (int i = 0; i < 32; i++) exp_regs[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(regs_o === '0, "R1 registers after reset", 64'(regs_o), 64'h0);
    chk({sdio_oe_o, sdo_o} === 2'b00, "R1 outputs after reset", 64'({sdio_oe_o, sdo_o}), 64'h0);
    cmp_on = 1;
    @(negedge clk);

    run_cycle(1'b0, 2, 3, 32'h0000_5CA7, 0, d);
    chk(regs_o[3*8 +: 8] === 8'hA7, "R3 R5 MSB write first byte", 64'(regs_o[3*8 +: 8]), 64'hA7);
    chk(regs_o[2*8 +: 8] === 8'h5C, "R5 decrement second byte", 64'(regs_o[2*8 +: 8]), 64'h5C);
    run_cycle(1'b0, 4, 7, 32'h4433_2211, 0, d);
    run_cycle(1'b1, 4, 7, 32'h0, 0, d);
    chk(d === 32'h4433_2211, "R6 four-byte MSB read", 64'(d), 64'h44332211);
    run_cycle(1'b1, 2, 3, 32'h0, 0, d);
    chk(d[15:0] === 16'h5CA7, "R6 two-byte read", 64'(d[15:0]), 64'h5CA7);

    run_cycle(1'b0, 1, 20, 32'hFF, 0, d);
    run_cycle(1'b1, 1, 20, 32'h0, 0, d);
    chk(d[7:0] === 8'h00, "R9 out-of-range reads zero", 64'(d[7:0]), 64'h0);

    run_cycle(1'b0, 1, 5, 32'h99, 16, d);
    chk(regs_o[4*8 +: 8] === 8'h44, "R4 extra edges after burst", 64'(regs_o[4*8 +: 8]), 64'h44);
    run_cycle(1'b1, 1, 6, 32'h0, 8, d);
    chk(d[7:0] === 8'h22, "R4 R6 read then extra edges", 64'(d[7:0]), 64'h22);

    abort_cycle(16'h001F, 5);
    p = '0;
    for (int i = 0; i < 8; i++) p[i] = (8'h02 >> (7 - i)) & 1'b1;
    p[11:8] = 4'hF;
    abort_cycle(p, 12);
    chk(regs_o[2*8 +: 8] === 8'h5C, "R2 aborted byte not written", 64'(regs_o[2*8 +: 8]), 64'h5C);
    run_cycle(1'b0, 1, 2, 32'h6B, 0, d);
    chk(regs_o[2*8 +: 8] === 8'h6B, "R2 clean cycle after abort", 64'(regs_o[2*8 +: 8]), 64'h6B);

    run_cycle(1'b0, 1, 0, 32'h01, 0, d);
    run_cycle(1'b0, 3, 1, 32'h0056_3412, 0, d);
    chk(regs_o[1*8 +: 8] === 8'h12, "R3 R5 LSB write increments", 64'(regs_o[1*8 +: 8]), 64'h12);
    chk(regs_o[3*8 +: 8] === 8'h56, "R5 LSB third byte", 64'(regs_o[3*8 +: 8]), 64'h56);
    run_cycle(1'b1, 3, 1, 32'h0, 0, d);
    chk(d[23:0] === 24'h563412, "R6 LSB read", 64'(d[23:0]), 64'h563412);

    run_cycle(1'b0, 2, 0, 32'h0000_1E00, 0, d);
    chk(regs_o[1*8 +: 8] === 8'h1E, "R8 setting held for rest of cycle", 64'(regs_o[1*8 +: 8]), 64'h1E);
    run_cycle(1'b1, 1, 1, 32'h0, 0, d);
    chk(d[7:0] === 8'h1E, "R8 MSB order after deselect", 64'(d[7:0]), 64'h1E);

    run_cycle(1'b0, 1, 0, 32'h02, 0, d);
    run_cycle(1'b1, 2, 3, 32'h0, 0, d);
    chk(d[15:0] === 16'h3456, "R7 4-wire MSB read", 64'(d[15:0]), 64'h3456);
    run_cycle(1'b0, 1, 0, 32'h03, 0, d);
    run_cycle(1'b1, 2, 6, 32'h0, 0, d);
    chk(d[15:0] === 16'h1122, "R7 4-wire LSB read", 64'(d[15:0]), 64'h1122);
    run_cycle(1'b0, 1, 0, 32'h00, 0, d);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule